// File: doc/BRIEF.md
# Floating Round-to-Integral Unit

The unit takes one IEEE-754 double-precision operand per clock and returns the nearest integral value in the direction chosen by a 2-bit rounding mode. The result is still a double. A flag reports whether rounding changed the value. The mode is meant to come from the two low bits of the floating-point control/status register that the surrounding pipeline holds. The unit accepts a new operand on every cycle and returns each result two clock edges after it was accepted.

Inside the unit, the first stage registers the operand and its mode. The registered operand is then sorted into one of five operand classes, and each class selects how the result is formed:

- **NAN**: a NaN is quietened and passed on.
- **INF**: ±infinity is passed on unchanged.
- **WHOLE**: zero, or a magnitude of 2^52 or more, is passed on unchanged.
- **BELOW**: a nonzero magnitude under one gives a signed zero or a signed one.
- **MIXED**: the operand has both integer and fraction bits. The fraction bits are cleared, an increment of one integer unit may be added, and the exponent is raised if that increment carries out of the significand.

The second stage registers the selected result. Each operand's class depends only on its own exponent and fraction bits. There are no transitions between classes from one operand to the next.

Top module: `rint_unit`

## Requirements
- R1: After reset `out_valid` is low. An operand sampled with `in_valid` high at one rising edge gives `out_valid` high after the following rising edge. Results come out in the order the operands went in, one per cycle when operands arrive back to back.
- R2: Mode 0 (nearest) returns whichever of the floor and ceiling neighbours is strictly closer to the operand.
- R3: In mode 0, an operand exactly halfway between two integers rounds to the even one, for example 2.5 gives 2.0 and 3.5 gives 4.0.
- R4: Mode 1 rounds toward zero: the floor for positive operands and the ceiling otherwise. The result magnitude never exceeds the operand magnitude.
- R5: Mode 2 returns the ceiling and mode 3 returns the floor.
- R6: For a non-NaN operand, `out_inexact` is high exactly when the result differs from the operand.
- R7: An operand whose unbiased exponent is 52 or more (biased exponent field in bits 62:52 of at least 1075) is passed through unchanged with `out_inexact` low.
- R8: ±infinity and ±zero are passed through unchanged. A NaN (exponent field all ones, fraction in bits 51:0 nonzero) is passed through with bit 51 set. Neither raises `out_inexact`.
- R9: The result keeps the operand's sign (bit 63), including a zero result: -0.3 rounded toward zero gives -0.0.
- R10: When the rounding increment carries out of the significand, the exponent rises by one and the fraction becomes zero, for example 1.5 to nearest gives 2.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and mode are valid this cycle |
| in_op | input | 64 | Double-precision operand |
| in_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 up, 3 down |
| out_valid | output | 1 | Result is valid this cycle |
| out_res | output | 64 | Integral result in double-precision format |
| out_inexact | output | 1 | Result differs from the operand |

## Verification
Positive and negative operands with fractions both above and below one half are sent through every mode. This separates the four directions, and it separates rounding by distance from plain truncation.

Exact halves show whether ties go to the even neighbour. The tie cases include 0.5 and -0.5, and a half just above 2^51, where only the last fraction bit is set.

Operands just under a power of two, sent with an upward increment, show whether the carry renormalises the result. Zeros, subnormals, large integers, infinities and signalling NaNs show the passthrough classes and the rule for the inexact flag.

// File: rtl/rint_pkg.sv
package rint_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rnd_mode_e;

    typedef enum logic [2:0] {
        CLS_NAN,
        CLS_INF,
        CLS_WHOLE,
        CLS_BELOW,
        CLS_MIXED
    } op_class_e;

endpackage

// File: rtl/rint_classify.sv
module rint_classify
    import rint_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [FRAC_W-1:0] frac_in,
    output op_class_e         cls
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] EXP_ALL_ONES = '1;

    always_comb begin
        if (exp_in == EXP_ALL_ONES) begin
            cls = (frac_in != '0) ? CLS_NAN : CLS_INF;
        end else if (exp_in == '0 && frac_in == '0) begin
            cls = CLS_WHOLE;
        end else if (int'(exp_in) < BIAS) begin
            cls = CLS_BELOW;
        end else if (int'(exp_in) >= BIAS + FRAC_W) begin
            cls = CLS_WHOLE;
        end else begin
            cls = CLS_MIXED;
        end
    end

endmodule

// File: rtl/rint_below.sv
module rint_below
    import rint_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  rnd_mode_e         mode,
    output logic              take_one
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic in_upper_half;
    logic above_half;

    // Magnitude in [0.5, 1) when the exponent sits one below the bias.
    assign in_upper_half = (int'(exp_in) == BIAS - 1);
    assign above_half    = in_upper_half && (frac_in != '0);

    always_comb begin
        unique case (mode)
            RM_NEAREST: take_one = above_half;   // an exact half ties to zero (even)
            RM_ZERO:    take_one = 1'b0;
            RM_UP:      take_one = ~sign;
            RM_DOWN:    take_one = sign;
            default:    take_one = 1'b0;
        endcase
    end

endmodule

// File: rtl/rint_mixed.sv
module rint_mixed
    import rint_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  rnd_mode_e         mode,
    output logic [EXP_W-1:0]  exp_out,
    output logic [FRAC_W-1:0] frac_out,
    output logic              inexact
);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W = FRAC_W + 1;
    localparam logic [SIG_W:0] ONE = {{SIG_W{1'b0}}, 1'b1};

    logic [SIG_W:0] sig, unit, lo_mask, kept, summed;
    logic           guard, sticky, lsb, inc;
    logic           unused_hidden;
    int             fb;

    always_comb begin
        // Number of fraction bits below the binary point.
        fb = FRAC_W - (int'(exp_in) - BIAS);
        if (fb < 1) begin
            fb = 1;
        end else if (fb > FRAC_W) begin
            fb = FRAC_W;
        end
        sig     = {1'b0, 1'b1, frac_in};
        unit    = ONE << fb;
        lo_mask = unit - ONE;
        inexact = |(sig & lo_mask);
        guard   = |(sig & (unit >> 1));
        sticky  = |(sig & (lo_mask >> 1));
        lsb     = |(sig & unit);

        unique case (mode)
            RM_NEAREST: inc = guard & (sticky | lsb);
            RM_ZERO:    inc = 1'b0;
            RM_UP:      inc = ~sign & inexact;
            RM_DOWN:    inc = sign & inexact;
            default:    inc = 1'b0;
        endcase

        kept   = sig & ~lo_mask;
        summed = kept + (inc ? unit : '0);

        if (summed[SIG_W]) begin
            // Carry out of the significand: renormalise to 1.0 x 2^(e+1).
            exp_out  = exp_in + EXP_W'(1);
            frac_out = '0;
        end else begin
            exp_out  = exp_in;
            frac_out = summed[FRAC_W-1:0];
        end
    end

    assign unused_hidden = summed[FRAC_W];

endmodule

// File: rtl/rint_unit.sv
module rint_unit
    import rint_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   in_op,
    input  logic [1:0]              in_mode,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W:0]   out_res,
    output logic                    out_inexact
);
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] BIAS_EXP = EXP_W'(BIAS);
    localparam logic [W-1:0]     QUIET    = {{(W-1){1'b0}}, 1'b1} << (FRAC_W - 1);

    // Stage 1: captured operand
    logic           s1_valid;
    logic [W-1:0]   s1_op;
    rnd_mode_e      s1_mode;

    logic               s1_sign;
    logic [EXP_W-1:0]   s1_exp;
    logic [FRAC_W-1:0]  s1_frac;
    op_class_e          cls;
    logic               below_one;
    logic [EXP_W-1:0]   mx_exp;
    logic [FRAC_W-1:0]  mx_frac;
    logic               mx_inexact;
    logic [W-1:0]       res_d;
    logic               inexact_d;

    assign s1_sign = s1_op[W-1];
    assign s1_exp  = s1_op[FRAC_W +: EXP_W];
    assign s1_frac = s1_op[FRAC_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= '0;
            s1_mode  <= RM_NEAREST;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_op   <= in_op;
                s1_mode <= rnd_mode_e'(in_mode);
            end
        end
    end

    rint_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .exp_in  (s1_exp),
        .frac_in (s1_frac),
        .cls     (cls)
    );

    rint_below #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_below (
        .sign     (s1_sign),
        .exp_in   (s1_exp),
        .frac_in  (s1_frac),
        .mode     (s1_mode),
        .take_one (below_one)
    );

    rint_mixed #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mixed (
        .sign     (s1_sign),
        .exp_in   (s1_exp),
        .frac_in  (s1_frac),
        .mode     (s1_mode),
        .exp_out  (mx_exp),
        .frac_out (mx_frac),
        .inexact  (mx_inexact)
    );

    always_comb begin
        res_d     = s1_op;
        inexact_d = 1'b0;
        unique case (cls)
            CLS_NAN:   res_d = s1_op | QUIET;
            CLS_INF:   res_d = s1_op;
            CLS_WHOLE: res_d = s1_op;
            CLS_BELOW: begin
                res_d     = {s1_sign, (below_one ? BIAS_EXP : {EXP_W{1'b0}}), {FRAC_W{1'b0}}};
                inexact_d = 1'b1;
            end
            CLS_MIXED: begin
                res_d     = {s1_sign, mx_exp, mx_frac};
                inexact_d = mx_inexact;
            end
            default: res_d = s1_op;
        endcase
    end

    // Stage 2: registered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_res     <= '0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_res     <= res_d;
                out_inexact <= inexact_d;
            end
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    assert_sign_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_res[W-1] == $past(s1_op[W-1]));

    assert_inexact_diff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cls) != CLS_NAN) |-> (out_inexact == (out_res != $past(s1_op))));

    assert_large_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cls) == CLS_WHOLE) |-> (out_res == $past(s1_op) && !out_inexact));

    assert_nan_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cls) == CLS_NAN) |-> (out_res[FRAC_W-1] && !out_inexact));

    assert_toward_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(s1_mode) == RM_ZERO && $past(cls) != CLS_NAN)
            |-> (out_res[W-2:0] <= $past(s1_op[W-2:0])));

endmodule

// File: tb/tb_rint_unit.sv
module tb_rint_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_op = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [63:0] out_res;
    logic        out_inexact;

    int checks = 0;
    int fails  = 0;
    int results_seen = 0;
    int sent = 0;

    logic [63:0] exp_res_q[$];
    logic        exp_inx_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    rint_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_mode     (in_mode),
        .out_valid   (out_valid),
        .out_res     (out_res),
        .out_inexact (out_inexact)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic send(input logic [63:0] op, input logic [1:0] md,
                        input logic [63:0] er, input logic ei, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_mode  = md;
        exp_res_q.push_back(er);
        exp_inx_q.push_back(ei);
        tag_q.push_back(tag);
        sent++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pop expected items as results appear.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            results_seen++;
            if (exp_res_q.size() == 0) begin
                check(1'b0, "R1 unexpected result", out_res, 64'h0);
            end else begin
                logic [63:0] er;
                logic        ei;
                string       tg;
                er = exp_res_q.pop_front();
                ei = exp_inx_q.pop_front();
                tg = tag_q.pop_front();
                check(out_res == er, tg, out_res, er);
                check(out_inexact == ei, {tg, " inexact"}, {63'h0, out_inexact}, {63'h0, ei});
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", {63'h0, out_valid}, 64'h0);
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 1'b0, "R1 idle after reset", {63'h0, out_valid}, 64'h0);

        // R1: exact latency on an empty pipeline
        send(64'h4005_9999_9999_999A, 2'd0, 64'h4008_0000_0000_0000, 1'b1, "R1 latency 2.7 nearest");
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R1 not yet after one edge", {63'h0, out_valid}, 64'h0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1 valid after two edges", {63'h0, out_valid}, 64'h1);
        idle(2);

        // R2: nearest by distance
        send(64'hC005_9999_9999_999A, 2'd0, 64'hC008_0000_0000_0000, 1'b1, "R2 -2.7 nearest");
        send(64'h3FD3_3333_3333_3333, 2'd0, 64'h0000_0000_0000_0000, 1'b1, "R2 0.3 nearest");
        send(64'h3FE6_6666_6666_6666, 2'd0, 64'h3FF0_0000_0000_0000, 1'b1, "R2 0.7 nearest");
        // R3: ties to even
        send(64'h4004_0000_0000_0000, 2'd0, 64'h4000_0000_0000_0000, 1'b1, "R3 2.5 nearest");
        send(64'h400C_0000_0000_0000, 2'd0, 64'h4010_0000_0000_0000, 1'b1, "R3 3.5 nearest");
        send(64'h3FE0_0000_0000_0000, 2'd0, 64'h0000_0000_0000_0000, 1'b1, "R3 0.5 nearest");
        send(64'hBFE0_0000_0000_0000, 2'd0, 64'h8000_0000_0000_0000, 1'b1, "R3 R9 -0.5 nearest");
        send(64'h4320_0000_0000_0001, 2'd0, 64'h4320_0000_0000_0000, 1'b1, "R3 2^51+0.5 nearest");
        // R4: toward zero
        send(64'h4005_9999_9999_999A, 2'd1, 64'h4000_0000_0000_0000, 1'b1, "R4 2.7 zero");
        send(64'hC005_9999_9999_999A, 2'd1, 64'hC000_0000_0000_0000, 1'b1, "R4 -2.7 zero");
        send(64'hBFD3_3333_3333_3333, 2'd1, 64'h8000_0000_0000_0000, 1'b1, "R4 R9 -0.3 zero");
        send(64'h3FFF_FFFF_FFFF_FFFF, 2'd1, 64'h3FF0_0000_0000_0000, 1'b1, "R4 1.999 zero");
        idle(3);
        // R5: up and down
        send(64'h4005_9999_9999_999A, 2'd2, 64'h4008_0000_0000_0000, 1'b1, "R5 2.7 up");
        send(64'hC005_9999_9999_999A, 2'd2, 64'hC000_0000_0000_0000, 1'b1, "R5 -2.7 up");
        send(64'h4005_9999_9999_999A, 2'd3, 64'h4000_0000_0000_0000, 1'b1, "R5 2.7 down");
        send(64'hC005_9999_9999_999A, 2'd3, 64'hC008_0000_0000_0000, 1'b1, "R5 -2.7 down");
        send(64'hBFD3_3333_3333_3333, 2'd2, 64'h8000_0000_0000_0000, 1'b1, "R5 R9 -0.3 up");
        send(64'hBFD3_3333_3333_3333, 2'd3, 64'hBFF0_0000_0000_0000, 1'b1, "R5 -0.3 down");
        send(64'h3FD3_3333_3333_3333, 2'd2, 64'h3FF0_0000_0000_0000, 1'b1, "R5 0.3 up");
        send(64'h0000_0000_0000_0001, 2'd2, 64'h3FF0_0000_0000_0000, 1'b1, "R5 subnormal up");
        send(64'h0000_0000_0000_0001, 2'd0, 64'h0000_0000_0000_0000, 1'b1, "R2 subnormal nearest");
        // R6: exact inputs raise no flag
        send(64'h4008_0000_0000_0000, 2'd0, 64'h4008_0000_0000_0000, 1'b0, "R6 3.0 nearest");
        send(64'h3FF0_0000_0000_0000, 2'd3, 64'h3FF0_0000_0000_0000, 1'b0, "R6 1.0 down");
        send(64'h0000_0000_0000_0000, 2'd2, 64'h0000_0000_0000_0000, 1'b0, "R6 R8 +0 up");
        send(64'h8000_0000_0000_0000, 2'd3, 64'h8000_0000_0000_0000, 1'b0, "R6 R8 -0 down");
        // R7: large magnitudes
        send(64'h4330_0000_0000_0001, 2'd0, 64'h4330_0000_0000_0001, 1'b0, "R7 2^52+1 nearest");
        send(64'hC330_0000_0000_0001, 2'd2, 64'hC330_0000_0000_0001, 1'b0, "R7 -(2^52+1) up");
        // R8: specials
        send(64'h7FF0_0000_0000_0000, 2'd1, 64'h7FF0_0000_0000_0000, 1'b0, "R8 +inf zero");
        send(64'hFFF0_0000_0000_0000, 2'd0, 64'hFFF0_0000_0000_0000, 1'b0, "R8 -inf nearest");
        send(64'h7FF0_0000_0000_0001, 2'd0, 64'h7FF8_0000_0000_0001, 1'b0, "R8 sNaN quieted");
        send(64'hFFF8_0000_0000_0000, 2'd3, 64'hFFF8_0000_0000_0000, 1'b0, "R8 qNaN down");
        // R10: carry into the exponent
        send(64'h3FFF_FFFF_FFFF_FFFF, 2'd2, 64'h4000_0000_0000_0000, 1'b1, "R10 1.999 up");
        send(64'h3FF8_0000_0000_0000, 2'd0, 64'h4000_0000_0000_0000, 1'b1, "R10 1.5 nearest");
        send(64'hBFFF_FFFF_FFFF_FFFF, 2'd3, 64'hC000_0000_0000_0000, 1'b1, "R10 -1.999 down");
        idle(6);

        check(exp_res_q.size() == 0, "R1 all results returned",
              64'(exp_res_q.size()), 64'h0);
        check(results_seen == sent, "R1 result count",
              64'(results_seen), 64'(sent));
        finish_run();
    end

endmodule